// File: doc/BRIEF.md
# Deadline-Ranked Deflection Mesh Router

This block is one node of a two-dimensional mesh network on a chip. It has four neighbour links (north, east, south, west), a local injection input and a local ejection output, and it stores no flits. In every cycle it takes all arriving flits and updates the latency budget carried in each header. It then orders the flits by that budget and gives each one an output, all in one registered pass. A flit that cannot have its productive link goes out on another free link. It is never held back.

Each header holds a remaining latency budget and the timestamp written by the hop that last sent it. All nodes share one free-running timestamp. The router takes the time spent since the last hop (current time minus stamp, modulo the timestamp width) away from the budget, stopping at zero, and writes the current time into the stamp. Flits closer to their deadline take their productive links first. No per-flow state is kept.

Flit layout, most significant field first: destination X (COORD_W bits), destination Y (COORD_W), budget (TIME_W), stamp (TIME_W), payload (PAY_W). Link index order is north=0, east=1, south=2, west=3, and the injection input ranks as index 4.

Top module: `defl_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output valid is low.
- R2: Every accepted flit appears on exactly one output (a link or ejection) one clock after it is presented. No flit is dropped and none is created.
- R3: The outgoing budget equals the incoming budget minus ((now_i - stamp) modulo 2^TIME_W). The difference is correct across timestamp wrap.
- R4: When the transit time is equal to or larger than the budget, the outgoing budget is zero.
- R5: The outgoing stamp equals the now_i value of the cycle in which the flit was accepted.
- R6: The productive link follows XY order. Destination X greater than local X goes east and smaller goes west. With X equal, greater Y goes north and smaller Y goes south. Equal X and Y means ejection.
- R7: Among flits that contend for one link, the smallest budget takes it. Each loser, taken in budget order, goes to the lowest-index free link.
- R8: Equal budgets are ordered by input index: north, east, south, west, then injection.
- R9: The highest-ranked flit addressed to this node is ejected. Any further flit addressed here is deflected to the lowest-index free link. The ejected flit's destination always equals the local coordinates.
- R10: inj_ready_o is high exactly when fewer than four link inputs are valid. An injection offered while it is low leaves no trace on any output.
- R11: An accepted injected flit is updated, ranked and routed like a link flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TIME_W | Shared global timestamp |
| in_valid_i | input | 4 | Link input valids, index 0=N 1=E 2=S 3=W |
| in_flit_i | input | 4*FLIT_W | Link input flits, link k at [k*FLIT_W +: FLIT_W] |
| inj_valid_i | input | 1 | Local injection request |
| inj_flit_i | input | FLIT_W | Local injection flit |
| inj_ready_o | output | 1 | Injection accepted this cycle when high |
| out_valid_o | output | 4 | Link output valids |
| out_flit_o | output | 4*FLIT_W | Link output flits, same slicing as the inputs |
| ej_valid_o | output | 1 | Ejection valid |
| ej_flit_o | output | FLIT_W | Ejected flit |

## Verification
The hardest case to reach is a chain of deflections. This needs several flits aimed at one link, so that each loser must find the next free link in budget order. It also needs a second flit for this node that arrives when the ejection port is already taken. The stimulus sends all four links toward the east with four different budgets, and it sends a local flit and an injected flit with equal budgets to this node. Two further vectors move the timestamp across wrap and drive transit past the budget, which exercises both arithmetic edges of the header update.

// File: rtl/defl_pkg.sv
package defl_pkg;
    localparam int NET_PORTS = 4;
    localparam int ALL_IN    = NET_PORTS + 1;
    localparam int RANK_W    = $clog2(ALL_IN);
    localparam int PORT_SEL_W = 3;

    localparam logic [PORT_SEL_W-1:0] PORT_N = 3'd0;
    localparam logic [PORT_SEL_W-1:0] PORT_E = 3'd1;
    localparam logic [PORT_SEL_W-1:0] PORT_S = 3'd2;
    localparam logic [PORT_SEL_W-1:0] PORT_W = 3'd3;
    localparam logic [PORT_SEL_W-1:0] PORT_L = 3'd4;
endpackage

// File: rtl/defl_hdr_update.sv
module defl_hdr_update #(
    parameter int COORD_W = 3,
    parameter int TIME_W  = 8,
    parameter int PAY_W   = 8
) (
    input  logic [TIME_W-1:0]                   now_i,
    input  logic [2*COORD_W+2*TIME_W+PAY_W-1:0] flit_i,
    output logic [2*COORD_W+2*TIME_W+PAY_W-1:0] flit_o,
    output logic [TIME_W-1:0]                   budget_o
);
    localparam int STAMP_LSB = PAY_W;
    localparam int BUD_LSB   = PAY_W + TIME_W;

    logic [TIME_W-1:0] stamp;
    logic [TIME_W-1:0] budget_in;
    logic [TIME_W-1:0] transit;

    always_comb begin
        stamp     = flit_i[STAMP_LSB +: TIME_W];
        budget_in = flit_i[BUD_LSB +: TIME_W];
        // modular difference stays right across timestamp wrap
        transit   = now_i - stamp;
        budget_o  = (budget_in > transit) ? (budget_in - transit) : '0;
        flit_o    = flit_i;
        flit_o[BUD_LSB +: TIME_W]   = budget_o;
        flit_o[STAMP_LSB +: TIME_W] = now_i;
    end
endmodule

// File: rtl/defl_route.sv
module defl_route
    import defl_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int X_POS   = 2,
    parameter int Y_POS   = 2
) (
    input  logic [COORD_W-1:0]    dst_x_i,
    input  logic [COORD_W-1:0]    dst_y_i,
    output logic [PORT_SEL_W-1:0] port_o
);
    localparam logic [COORD_W-1:0] HOME_X = COORD_W'(X_POS);
    localparam logic [COORD_W-1:0] HOME_Y = COORD_W'(Y_POS);

    always_comb begin
        if (dst_x_i > HOME_X)      port_o = PORT_E;
        else if (dst_x_i < HOME_X) port_o = PORT_W;
        else if (dst_y_i > HOME_Y) port_o = PORT_N;
        else if (dst_y_i < HOME_Y) port_o = PORT_S;
        else                       port_o = PORT_L;
    end
endmodule

// File: rtl/defl_rank.sv
module defl_rank
    import defl_pkg::*;
#(
    parameter int TIME_W = 8
) (
    input  logic [ALL_IN-1:0]        valid_i,
    input  logic [ALL_IN*TIME_W-1:0] budget_i,
    output logic [ALL_IN*RANK_W-1:0] rank_o
);
    always_comb begin
        for (int i = 0; i < ALL_IN; i++) begin
            logic [RANK_W-1:0] cnt;
            cnt = '0;
            for (int j = 0; j < ALL_IN; j++) begin
                if (valid_i[j] && (j != i)) begin
                    if ((budget_i[j*TIME_W +: TIME_W] < budget_i[i*TIME_W +: TIME_W]) ||
                        ((budget_i[j*TIME_W +: TIME_W] == budget_i[i*TIME_W +: TIME_W]) && (j < i)))
                        cnt = cnt + 1'b1;
                end
            end
            rank_o[i*RANK_W +: RANK_W] = cnt;
        end
    end
endmodule

// File: rtl/defl_router.sv
module defl_router
    import defl_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int TIME_W  = 8,
    parameter int PAY_W   = 8,
    parameter int X_POS   = 2,
    parameter int Y_POS   = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [TIME_W-1:0]                             now_i,
    input  logic [3:0]                                    in_valid_i,
    input  logic [4*(2*COORD_W+2*TIME_W+PAY_W)-1:0]       in_flit_i,
    input  logic                                          inj_valid_i,
    input  logic [2*COORD_W+2*TIME_W+PAY_W-1:0]           inj_flit_i,
    output logic                                          inj_ready_o,
    output logic [3:0]                                    out_valid_o,
    output logic [4*(2*COORD_W+2*TIME_W+PAY_W)-1:0]       out_flit_o,
    output logic                                          ej_valid_o,
    output logic [2*COORD_W+2*TIME_W+PAY_W-1:0]           ej_flit_o
);
    localparam int FLIT_W    = 2*COORD_W + 2*TIME_W + PAY_W;
    localparam int STAMP_LSB = PAY_W;
    localparam int BUD_LSB   = PAY_W + TIME_W;
    localparam int DY_LSB    = PAY_W + 2*TIME_W;
    localparam int DX_LSB    = DY_LSB + COORD_W;
    localparam int CNT_W     = $clog2(ALL_IN + 1);

    typedef struct packed {
        logic [NET_PORTS-1:0]             ov;
        logic [NET_PORTS-1:0][FLIT_W-1:0] of;
        logic                             ev;
        logic [FLIT_W-1:0]                ef;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [ALL_IN-1:0]        cand_v;
    logic [FLIT_W-1:0]        cand_flit [ALL_IN];
    logic [FLIT_W-1:0]        upd_flit  [ALL_IN];
    logic [ALL_IN*TIME_W-1:0] upd_bud;
    logic [PORT_SEL_W-1:0]    want      [ALL_IN];
    logic [ALL_IN*RANK_W-1:0] rank;
    logic [CNT_W-1:0]         acc_cnt;

    assign inj_ready_o = ($countones(in_valid_i) < NET_PORTS);
    assign cand_v      = {inj_valid_i & inj_ready_o, in_valid_i};
    assign acc_cnt     = CNT_W'($countones(cand_v));

    generate
        for (genvar g = 0; g < ALL_IN; g++) begin : g_cand
            if (g < NET_PORTS) begin : g_net
                assign cand_flit[g] = in_flit_i[g*FLIT_W +: FLIT_W];
            end else begin : g_inj
                assign cand_flit[g] = inj_flit_i;
            end

            defl_hdr_update #(
                .COORD_W(COORD_W), .TIME_W(TIME_W), .PAY_W(PAY_W)
            ) u_hdr (
                .now_i   (now_i),
                .flit_i  (cand_flit[g]),
                .flit_o  (upd_flit[g]),
                .budget_o(upd_bud[g*TIME_W +: TIME_W])
            );

            defl_route #(
                .COORD_W(COORD_W), .X_POS(X_POS), .Y_POS(Y_POS)
            ) u_route (
                .dst_x_i(cand_flit[g][DX_LSB +: COORD_W]),
                .dst_y_i(cand_flit[g][DY_LSB +: COORD_W]),
                .port_o (want[g])
            );

            // budget can only shrink on the way through
            assert_budget_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
                cand_v[g] |-> (upd_bud[g*TIME_W +: TIME_W] <= cand_flit[g][BUD_LSB +: TIME_W]));
        end
    endgenerate

    defl_rank #(.TIME_W(TIME_W)) u_rank (
        .valid_i (cand_v),
        .budget_i(upd_bud),
        .rank_o  (rank)
    );

    // allocation in rank order: ejection or productive link, else first free link
    always_comb begin
        logic [NET_PORTS-1:0] used;
        logic                 ej_used;
        logic                 placed;
        state_d = '0;
        used    = '0;
        ej_used = 1'b0;
        placed  = 1'b0;
        for (int r = 0; r < ALL_IN; r++) begin
            for (int i = 0; i < ALL_IN; i++) begin
                if (cand_v[i] && (rank[i*RANK_W +: RANK_W] == RANK_W'(r))) begin
                    placed = 1'b0;
                    if (want[i] == PORT_L) begin
                        if (!ej_used) begin
                            ej_used    = 1'b1;
                            state_d.ev = 1'b1;
                            state_d.ef = upd_flit[i];
                            placed     = 1'b1;
                        end
                    end else if (!used[want[i][1:0]]) begin
                        used[want[i][1:0]]       = 1'b1;
                        state_d.ov[want[i][1:0]] = 1'b1;
                        state_d.of[want[i][1:0]] = upd_flit[i];
                        placed                   = 1'b1;
                    end
                    for (int k = 0; k < NET_PORTS; k++) begin
                        if (!placed && !used[k]) begin
                            used[k]       = 1'b1;
                            state_d.ov[k] = 1'b1;
                            state_d.of[k] = upd_flit[i];
                            placed        = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid_o = state_q.ov;
    assign out_flit_o  = state_q.of;
    assign ej_valid_o  = state_q.ev;
    assign ej_flit_o   = state_q.ef;

    // one output per accepted flit, one cycle later
    assert_conserve_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (CNT_W'($countones({out_valid_o, ej_valid_o})) == $past(acc_cnt)));

    // gating keeps the offered load within the link count
    assert_no_overcommit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt <= CNT_W'(NET_PORTS)));

    assert_eject_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid_o |-> ((ej_flit_o[DX_LSB +: COORD_W] == COORD_W'(X_POS)) &&
                        (ej_flit_o[DY_LSB +: COORD_W] == COORD_W'(Y_POS))));

    generate
        for (genvar p = 0; p < NET_PORTS; p++) begin : g_chk
            assert_stamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid_o[p] |-> (out_flit_o[p*FLIT_W + STAMP_LSB +: TIME_W] == $past(now_i)));
        end
        for (genvar r = 0; r < ALL_IN; r++) begin : g_rank_chk
            logic [ALL_IN-1:0] hit;
            for (genvar i = 0; i < ALL_IN; i++) begin : g_hit
                assign hit[i] = cand_v[i] && (rank[i*RANK_W +: RANK_W] == RANK_W'(r));
            end
            // strict total order: no two flits share a rank
            assert_rank_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(hit));
        end
    endgenerate
endmodule

// File: tb/defl_router_bench.sv
module defl_router_bench;
    localparam int CW = 3;
    localparam int TW = 8;
    localparam int PW = 8;
    localparam int FW = 2*CW + 2*TW + PW;
    localparam int NV = 9;
    localparam logic [FW-1:0] Z = '0;

    function automatic logic [FW-1:0] mk(int dx, int dy, int bud, int st, int pay);
        return {CW'(dx), CW'(dy), TW'(bud), TW'(st), PW'(pay)};
    endfunction

    typedef struct packed {
        logic [3:0]         iv;
        logic [3:0][FW-1:0] fl;
        logic               inv;
        logic [FW-1:0]      inf;
        logic [TW-1:0]      now;
        logic               rdy;
        logic [3:0]         ov;
        logic [3:0][FW-1:0] of;
        logic               ev;
        logic [FW-1:0]      ef;
    } vec_t;

    // flit lists are written west, south, east, north (index 3 down to 0)
    localparam vec_t VECS [NV] = '{
        // R3 R6: west input heads east, transit 5
        '{4'b1000, {mk(4,2,50,10,'hA1), Z, Z, Z}, 1'b0, Z, 8'd15, 1'b1,
          4'b0010, {Z, Z, mk(4,2,45,15,'hA1), Z}, 1'b0, Z},
        // R7: smaller budget takes east, loser to link 0
        '{4'b0101, {Z, mk(5,5,20,20,'h02), Z, mk(3,1,40,20,'h01)}, 1'b0, Z, 8'd22, 1'b1,
          4'b0011, {Z, Z, mk(5,5,18,22,'h02), mk(3,1,38,22,'h01)}, 1'b0, Z},
        // R8: equal budgets, east input beats west for north
        '{4'b1010, {mk(2,7,30,30,'h13), Z, mk(2,4,30,30,'h11), Z}, 1'b0, Z, 8'd30, 1'b1,
          4'b0011, {Z, Z, mk(2,7,30,30,'h13), mk(2,4,30,30,'h11)}, 1'b0, Z},
        // R9: two flits for this node, north ejects, west deflects
        '{4'b1001, {mk(2,2,9,101,'h23), Z, Z, mk(2,2,10,100,'h21)}, 1'b0, Z, 8'd103, 1'b1,
          4'b0001, {Z, Z, Z, mk(2,2,7,103,'h23)}, 1'b1, mk(2,2,7,103,'h21)},
        // R4 R11: clamp to zero, injected flit deflected
        '{4'b0100, {Z, mk(0,2,3,200,'h31), Z, Z}, 1'b1, mk(1,2,100,210,'h44), 8'd210, 1'b1,
          4'b1001, {mk(0,2,0,210,'h31), Z, Z, mk(1,2,100,210,'h44)}, 1'b0, Z},
        // R3: timestamp wrap, 5 - 250 = 11 mod 256
        '{4'b0001, {Z, Z, Z, mk(2,0,60,250,'h51)}, 1'b0, Z, 8'd5, 1'b1,
          4'b0100, {Z, mk(2,0,49,5,'h51), Z, Z}, 1'b0, Z},
        // R10 R6: full load, injection refused
        '{4'b1111, {mk(2,0,4,7,'h64), mk(4,2,3,7,'h63), mk(0,2,2,7,'h62), mk(2,5,1,7,'h61)},
          1'b1, mk(2,2,9,7,'h6F), 8'd7, 1'b0,
          4'b1111, {mk(0,2,2,7,'h62), mk(2,0,4,7,'h64), mk(4,2,3,7,'h63), mk(2,5,1,7,'h61)}, 1'b0, Z},
        // R7: four flits aimed east, deflection chain in budget order
        '{4'b1111, {mk(7,2,6,40,'h84), mk(7,2,7,40,'h83), mk(7,2,8,40,'h82), mk(7,2,9,40,'h81)},
          1'b0, Z, 8'd40, 1'b0,
          4'b1111, {mk(7,2,9,40,'h81), mk(7,2,8,40,'h82), mk(7,2,6,40,'h84), mk(7,2,7,40,'h83)}, 1'b0, Z},
        // R9 R10 R11: injection ties with north for ejection and loses
        '{4'b1011, {mk(6,2,1,50,'h74), Z, mk(2,6,2,50,'h72), mk(2,2,5,50,'h71)},
          1'b1, mk(2,2,5,50,'h75), 8'd50, 1'b1,
          4'b0111, {Z, mk(2,2,5,50,'h75), mk(6,2,1,50,'h74), mk(2,6,2,50,'h72)}, 1'b1, mk(2,2,5,50,'h71)}
    };

    localparam logic [4*8-1:0] TAG_UNUSED = '0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TW-1:0]     now_i = '0;
    logic [3:0]        in_valid_i = '0;
    logic [4*FW-1:0]   in_flit_i = '0;
    logic              inj_valid_i = 1'b0;
    logic [FW-1:0]     inj_flit_i = '0;
    logic              inj_ready_o;
    logic [3:0]        out_valid_o;
    logic [4*FW-1:0]   out_flit_o;
    logic              ej_valid_o;
    logic [FW-1:0]     ej_flit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    defl_router #(.COORD_W(CW), .TIME_W(TW), .PAY_W(PW), .X_POS(2), .Y_POS(2)) u_defl_router (
        .clk(clk), .rst_n(rst_n), .now_i(now_i),
        .in_valid_i(in_valid_i), .in_flit_i(in_flit_i),
        .inj_valid_i(inj_valid_i), .inj_flit_i(inj_flit_i), .inj_ready_o(inj_ready_o),
        .out_valid_o(out_valid_o), .out_flit_o(out_flit_o),
        .ej_valid_o(ej_valid_o), .ej_flit_o(ej_flit_o)
    );

    task automatic check(string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid_i  = '0;
        in_flit_i   = '0;
        inj_valid_i = 1'b0;
        inj_flit_i  = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs low under reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 link valids in reset", 128'(out_valid_o), 128'(0));
        check("R1 eject valid in reset", 128'(ej_valid_o), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 link valids after reset", 128'(out_valid_o), 128'(0));

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            in_valid_i  = VECS[v].iv;
            in_flit_i   = VECS[v].fl;
            inj_valid_i = VECS[v].inv;
            inj_flit_i  = VECS[v].inf;
            now_i       = VECS[v].now;
            #1;
            check($sformatf("R10 vec%0d inj_ready", v), 128'(inj_ready_o), 128'(VECS[v].rdy));
            @(posedge clk);
            #1;
            check($sformatf("R2 vec%0d link valids", v), 128'(out_valid_o), 128'(VECS[v].ov));
            check($sformatf("R9 vec%0d eject valid", v), 128'(ej_valid_o), 128'(VECS[v].ev));
            if (VECS[v].ev)
                check($sformatf("R9 vec%0d eject flit", v), 128'(ej_flit_o), 128'(VECS[v].ef));
            for (int k = 0; k < 4; k++) begin
                if (VECS[v].ov[k])
                    check($sformatf("R7 vec%0d link%0d flit", v, k),
                          128'(out_flit_o[k*FW +: FW]), 128'(VECS[v].of[k]));
            end
        end

        // R2: with nothing offered nothing leaves, and the refused injection never surfaces (R10)
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        check("R2 idle link valids", 128'(out_valid_o), 128'(0));
        check("R10 idle eject valid", 128'(ej_valid_o), 128'(0));

        // R10: refused injection under full load, then idle, leaves only the four link flits
        @(negedge clk);
        in_valid_i  = 4'b1111;
        in_flit_i   = {mk(2,5,9,60,'h94), mk(2,5,9,60,'h93), mk(2,5,9,60,'h92), mk(2,5,9,60,'h91)};
        inj_valid_i = 1'b1;
        inj_flit_i  = mk(2,2,1,60,'h9F);
        now_i       = 8'd60;
        @(posedge clk);
        #1;
        check("R10 full load link valids", 128'(out_valid_o), 128'(4'b1111));
        check("R10 full load eject", 128'(ej_valid_o), 128'(0));
        check("R8 north input keeps north link", 128'(out_flit_o[0 +: FW]), 128'(mk(2,5,9,60,'h91)));
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        check("R10 refused flit absent", 128'({out_valid_o, ej_valid_o}), 128'(0));

        // R1: reset in the middle of traffic clears outputs
        @(negedge clk);
        in_valid_i = 4'b0001;
        in_flit_i  = {Z, Z, Z, mk(5,2,20,60,'hB1)};
        rst_n      = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 128'({out_valid_o, ej_valid_o}), 128'(0));
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule